// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel engine. It copies data from a source address to a destination address over a simple request/grant memory bus. Software loads a control word, a start address for each side and a byte count while the channel is idle, then pulses start. The engine runs one read cycle from the source followed by one write cycle to the destination for every transfer unit. The read data is held in an internal register between the two cycles. After each unit it steps both addresses and lowers the remaining count. When the count reaches zero it goes idle and pulses done.

The control word sets five things: whether the channel moves one unit per external request or runs without stopping, how each address steps, the unit size, the device port size, and whether the CPU may take the bus back. When bus hand-back is enabled, a CPU hold request seen while the channel owns the bus makes the channel let go of the bus at the gap after a completed write. The channel asks for the bus again, at its held addresses, once the CPU withdraws its request. A start with an inconsistent setup raises an error flag, and the channel stays idle.

Top module: `dma_seq`

## Requirements
- R1: After reset the control word, the addresses and the remaining count are zero, and active, done, err and bus_req are low.
- R2: With control bit 0 at 0 (continuous mode), one start pulse moves unit after unit with no further request until the remaining count is zero.
- R3: Control bits [6:5] give the unit size: 11 is 1 byte, 10 is 2 bytes, 00 or 01 is 4 bytes. bus_be selects the byte lanes of the unit from the low address bits (one lane for a byte, a lane pair for a halfword, all four lanes for a word). The unit read from its source lanes is written to its destination lanes.
- R4: Control bits [2:1] set the source stepping and bits [4:3] set the destination stepping: 00 adds the unit size after each unit, 01 subtracts it, and 10 or 11 holds the address fixed.
- R5: With control bit 0 at 1 (single mode), the channel moves exactly one unit for each xfer_req pulse. bus_req stays low while it waits for the next pulse.
- R6: With control bit 9 at 1, a cpu_hold seen when a write completes, with count still remaining, drops bus_req. No bus cycle runs until cpu_hold falls, and then the transfer resumes at the held addresses. With bit 9 at 0, the channel keeps bus_req high through cpu_hold.
- R7: The remaining count falls by the unit size each time a write completes.
- R8: When the count reaches zero, done is high for exactly one clock, and active falls in that same clock. This holds even if cpu_hold is raised during the final write.
- R9: In single mode, control bits [8:7] (port size, same encoding as R3) must give the same size as the unit. In continuous mode they are ignored.
- R10: A start whose count is zero or not a multiple of the unit size, or that breaks R9, sets err and leaves the channel idle. A valid start clears err.
- R11: Each bus cycle holds bus_valid, bus_addr and bus_we steady until bus_rdy is seen high. bus_valid is high only while bus_req is high. The first cycle of a unit is the read, and it waits for bus_gnt.
- R12: cfg_load and start are ignored while the channel is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load control word, addresses and count (idle only) |
| cfg_ctrl | input | 10 | Control word (fields per R3, R4, R5, R6, R9) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Byte count |
| start | input | 1 | Start pulse |
| xfer_req | input | 1 | Per-unit request in single mode |
| cpu_hold | input | 1 | CPU request for the bus |
| bus_req | output | 1 | Channel requests or owns the bus |
| bus_gnt | input | 1 | Bus granted |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | AW | Cycle address |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_rdy | input | 1 | Cycle completes |
| active | output | 1 | Channel running |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last start was rejected |
| remain | output | CW | Remaining byte count |

## Verification
The clash that matters is completion of the last write landing in the same cycle as a bus hand-back request. The channel could either finish or enter the yielded wait at that moment. The bench raises cpu_hold during the first bus cycle of a one-unit transfer with hand-back enabled, and keeps it high past the end. It then requires one done pulse, active low, a zero count and bus_req low, and it requires this without any release of cpu_hold. A second clash is a reconfiguration or start arriving mid-run. It is judged by comparing the final memory image with a byte-level reference copy of the original setup.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int DW     = 32;
    localparam int CTRL_W = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_ARB,
        S_RD,
        S_WR,
        S_YIELD
    } state_t;

    // Control word, most significant field first
    typedef struct packed {
        logic       yield_en;   // [9]
        logic [1:0] port_sz;    // [8:7]
        logic [1:0] unit_sz;    // [6:5]
        logic [1:0] dst_mode;   // [4:3]
        logic [1:0] src_mode;   // [2:1]
        logic       single;     // [0]
    } ctrl_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b11:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] lane_ofs(input logic [2:0] nb, input logic [1:0] lo);
        case (nb)
            3'd1:    return lo;
            3'd2:    return {lo[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] nb);
        case (nb)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] data_mask(input logic [2:0] nb);
        case (nb)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic [2:0]    nbytes,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] delta;
    assign delta = AW'(nbytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            case (mode)
                2'b00:   addr <= addr + delta;
                2'b01:   addr <= addr - delta;
                default: addr <= addr;
            endcase
        end
    end

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_seq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          single,
    input  logic [1:0]    unit_sz,
    input  logic [1:0]    port_sz,
    input  logic [CW-1:0] count,
    output logic [2:0]    nbytes,
    output logic          ok
);

    logic [2:0] port_bytes;
    logic       misaligned;
    logic       port_bad;

    always_comb begin
        nbytes     = size_bytes(unit_sz);
        port_bytes = size_bytes(port_sz);
        misaligned = ((nbytes == 3'd2) && count[0]) ||
                     ((nbytes == 3'd4) && (count[1:0] != 2'b00));
        port_bad   = single && (port_bytes != nbytes);
        ok         = (count != '0) && !misaligned && !port_bad;
    end

endmodule

// File: rtl/dma_lane_mux.sv
module dma_lane_mux
    import dma_seq_pkg::*;
(
    input  logic [DW-1:0] rbuf,
    input  logic [1:0]    src_lo,
    input  logic [1:0]    dst_lo,
    input  logic [2:0]    nbytes,
    input  logic          wr_phase,
    output logic [DW-1:0] wdata,
    output logic [3:0]    be
);

    logic [1:0]    s_ofs;
    logic [1:0]    d_ofs;
    logic [DW-1:0] unit_val;

    always_comb begin
        s_ofs    = lane_ofs(nbytes, src_lo);
        d_ofs    = lane_ofs(nbytes, dst_lo);
        unit_val = (rbuf >> {s_ofs, 3'b000}) & data_mask(nbytes);
        wdata    = unit_val << {d_ofs, 3'b000};
        be       = lane_mask(nbytes) << (wr_phase ? d_ofs : s_ofs);
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [AW-1:0]     cfg_src,
    input  logic [AW-1:0]     cfg_dst,
    input  logic [CW-1:0]     cfg_count,
    input  logic              start,
    input  logic              xfer_req,
    input  logic              cpu_hold,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [3:0]        bus_be,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_rdy,
    output logic              active,
    output logic              done,
    output logic              err
    ,
    output logic [CW-1:0]     remain
);

    localparam int NSIDE = 2;   // 0: source, 1: destination

    ctrl_t         ctrl_q;
    state_t        st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rbuf_q;
    logic          done_q;
    logic          err_q;

    logic          cfg_ok;
    logic [2:0]    nbytes;
    logic          idle;
    logic          ld;
    logic          step_en;
    logic          last_unit;

    logic [AW-1:0] side_addr [NSIDE];
    logic [AW-1:0] side_init [NSIDE];
    logic [1:0]    side_mode [NSIDE];

    assign idle      = (st_q == S_IDLE);
    assign ld        = cfg_load && idle;
    assign step_en   = (st_q == S_WR) && bus_rdy;
    assign last_unit = (cnt_q == CW'(nbytes));

    assign side_init[0] = cfg_src;
    assign side_init[1] = cfg_dst;
    assign side_mode[0] = ctrl_q.src_mode;
    assign side_mode[1] = ctrl_q.dst_mode;

    genvar g;
    generate
        for (g = 0; g < NSIDE; g++) begin : g_side
            dma_addr_gen #(.AW(AW)) u_addr (
                .clk       (clk),
                .rst       (rst),
                .load      (ld),
                .load_addr (side_init[g]),
                .step      (step_en),
                .mode      (side_mode[g]),
                .nbytes    (nbytes),
                .addr      (side_addr[g])
            );
        end
    endgenerate

    dma_cfg_check #(.CW(CW)) u_cfg (
        .single  (ctrl_q.single),
        .unit_sz (ctrl_q.unit_sz),
        .port_sz (ctrl_q.port_sz),
        .count   (cnt_q),
        .nbytes  (nbytes),
        .ok      (cfg_ok)
    );

    dma_lane_mux u_lane (
        .rbuf     (rbuf_q),
        .src_lo   (side_addr[0][1:0]),
        .dst_lo   (side_addr[1][1:0]),
        .nbytes   (nbytes),
        .wr_phase (st_q == S_WR),
        .wdata    (bus_wdata),
        .be       (bus_be)
    );

    // Sequencing of one unit: arbitration, read, write, then decide
    always_comb begin
        st_d = st_q;
        case (st_q)
            S_IDLE:  if (start && cfg_ok) st_d = ctrl_q.single ? S_WAIT : S_ARB;
            S_WAIT:  if (xfer_req) st_d = S_ARB;
            S_ARB:   if (bus_gnt) st_d = S_RD;
            S_RD:    if (bus_rdy) st_d = S_WR;
            S_WR: begin
                if (bus_rdy) begin
                    if (last_unit)                           st_d = S_IDLE;
                    else if (ctrl_q.single)                  st_d = S_WAIT;
                    else if (ctrl_q.yield_en && cpu_hold)    st_d = S_YIELD;
                    else                                     st_d = S_RD;
                end
            end
            S_YIELD: if (!cpu_hold) st_d = S_ARB;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            ctrl_q <= '0;
            cnt_q  <= '0;
            rbuf_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= step_en && last_unit;
            if (ld) begin
                ctrl_q <= ctrl_t'(cfg_ctrl);
                cnt_q  <= cfg_count;
            end else if (step_en) begin
                cnt_q  <= cnt_q - CW'(nbytes);
            end
            if (idle && start) begin
                err_q <= !cfg_ok;
            end
            if ((st_q == S_RD) && bus_rdy) begin
                rbuf_q <= bus_rdata;
            end
        end
    end

    assign bus_req   = (st_q == S_ARB) || (st_q == S_RD) || (st_q == S_WR);
    assign bus_valid = (st_q == S_RD) || (st_q == S_WR);
    assign bus_we    = (st_q == S_WR);
    assign bus_addr  = (st_q == S_WR) ? side_addr[1] : side_addr[0];
    assign active    = !idle;
    assign done      = done_q;
    assign err       = err_q;
    assign remain    = cnt_q;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_valid,
    input logic          bus_we,
    input logic          bus_rdy,
    input logic [AW-1:0] bus_addr,
    input logic [3:0]    bus_be,
    input logic          done,
    input logic          err,
    input logic          active,
    input logic          single,
    input logic          yield_en,
    input logic [1:0]    unit_sz,
    input logic [CW-1:0] remain
);

    logic [CW-1:0] step_w;
    assign step_w = CW'(size_bytes(unit_sz));

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8

    AST_VALID_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_req);  // R11

    AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_rdy) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));  // R11

    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !active);  // R10

    AST_KEEP_BUS: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !single && !yield_en) |-> !$fell(bus_req));  // R6

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (unit_sz == 2'b11)) |-> ($countones(bus_be) == 1));  // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && (remain != $past(remain))) |-> (($past(remain) - remain) == step_w));  // R7

endmodule

bind dma_seq dma_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_rdy   (bus_rdy),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .done      (done),
    .err       (err),
    .active    (active),
    .single    (ctrl_q.single),
    .yield_en  (ctrl_q.yield_en),
    .unit_sz   (ctrl_q.unit_sz),
    .remain    (remain)
);

// File: tb/dma_seq_bench.sv
`timescale 1ns/1ps
module dma_seq_bench;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [9:0]    cfg_ctrl = '0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          start = 1'b0;
    logic          xfer_req = 1'b0;
    logic          cpu_hold = 1'b0;
    logic          gnt_block = 1'b0;
    logic          bus_req, bus_gnt, bus_valid, bus_we, bus_rdy;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          active, done, err;
    logic [CW-1:0] remain;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    logic fill_req = 1'b0;

    logic [31:0] mem [0:63];
    logic [7:0]  rb  [0:255];
    int          wcnt;

    always #4 clk = ~clk;

    dma_seq #(.AW(AW), .CW(CW)) u_dma_seq (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .start(start), .xfer_req(xfer_req), .cpu_hold(cpu_hold),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .active(active), .done(done), .err(err), .remain(remain)
    );

    function automatic logic [7:0] byte_val(input int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] mem_byte(input int b);
        return mem[b >> 2][8 * (b % 4) +: 8];
    endfunction

    // Memory and slave model
    assign bus_gnt   = bus_req && !cpu_hold && !gnt_block;
    assign bus_rdata = mem[bus_addr[7:2]];

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 64; i++)
                mem[i] <= {byte_val(4*i+3), byte_val(4*i+2), byte_val(4*i+1), byte_val(4*i)};
            bus_rdy <= 1'b0;
            wcnt    <= 0;
        end else begin
            bus_rdy <= 1'b0;
            if (bus_valid && !bus_rdy) begin
                if (wcnt >= lat) begin
                    bus_rdy <= 1'b1;
                    wcnt    <= 0;
                    if (bus_we)
                        for (int j = 0; j < 4; j++)
                            if (bus_be[j]) mem[bus_addr[7:2]][8*j +: 8] <= bus_wdata[8*j +: 8];
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(input logic single, input logic [1:0] sm, input logic [1:0] dm,
                                      input logic [1:0] unit, input logic [1:0] port, input logic yen);
        return {yen, port, unit, dm, sm, single};
    endfunction

    function automatic int nb_of(input logic [1:0] code);
        return (code == 2'b11) ? 1 : (code == 2'b10) ? 2 : 4;
    endfunction

    task automatic init_mem();
        for (int b = 0; b < 256; b++) rb[b] = byte_val(b);
        @(negedge clk) fill_req = 1'b1;
        @(negedge clk) fill_req = 1'b0;
    endtask

    // Byte-level reference of a whole transfer
    task automatic ref_xfer(input logic [9:0] c, input int src, input int dst, input int cnt);
        int nb, s, d;
        nb = nb_of(c[6:5]);
        s = src; d = dst;
        for (int u = 0; u < cnt / nb; u++) begin
            for (int j = 0; j < nb; j++) rb[(d + j) & 255] = rb[(s + j) & 255];
            if (c[2:1] == 2'b00) s = s + nb; else if (c[2:1] == 2'b01) s = s - nb;
            if (c[4:3] == 2'b00) d = d + nb; else if (c[4:3] == 2'b01) d = d - nb;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int b = 0; b < 256; b++) if (mem_byte(b) !== rb[b]) bad++;
        chk(req, "memory bytes differing from reference", bad, 0);
    endtask

    task automatic cfg(input logic [9:0] c, input int src, input int dst, input int cnt);
        @(negedge clk);
        cfg_load = 1'b1; cfg_ctrl = c; cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cnt);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic go();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk) xfer_req = 1'b1;
        @(negedge clk) xfer_req = 1'b0;
    endtask

    task automatic wait_idle(input int limit, output int pulses, output int ok);
        pulses = 0; ok = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) pulses++;
            if (!active) begin ok = 1; break; end
        end
        @(negedge clk);
        if (done) pulses++;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (bus_valid) break;
        end
    endtask

    task automatic t_reset();
        chk("R1", "active after reset", active, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "err after reset", err, 0);
        chk("R1", "bus_req after reset", bus_req, 0);
        chk("R1", "remain after reset", remain, 0);
    endtask

    task automatic t_grant_word();
        logic [9:0] c; int p, ok;
        c = mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 0);
        lat = 0; init_mem(); gnt_block = 1'b1;
        cfg(c, 8'h00, 8'h80, 16); ref_xfer(c, 8'h00, 8'h80, 16);
        go();
        repeat (10) @(negedge clk);
        chk("R11", "bus_req while grant withheld", bus_req, 1);
        chk("R11", "bus_valid while grant withheld", bus_valid, 0);
        chk("R11", "remain while grant withheld", remain, 16);
        gnt_block = 1'b0;
        wait_valid();
        chk("R11", "first cycle is a read", bus_we, 0);
        chk("R3", "word byte enables", bus_be, 4'b1111);
        wait_idle(500, p, ok);
        chk("R2", "continuous run finished on its own", ok, 1);
        chk("R8", "done pulse count", p, 1);
        chk("R7", "remain at end", remain, 0);
        cmp_mem("R2 R4");
    endtask

    task automatic t_byte_dec_ignore();
        logic [9:0] c; int p, ok;
        c = mk(0, 2'b01, 2'b00, 2'b11, 2'b11, 0);
        lat = 2; init_mem();
        cfg(c, 8'h13, 8'hA1, 6); ref_xfer(c, 8'h13, 8'hA1, 6);
        go();
        wait_valid();
        chk("R3", "byte lane for source 0x13", bus_be, 4'b1000);
        repeat (3) @(negedge clk);
        cfg(mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 0), 8'h40, 8'h50, 64);
        go();
        wait_idle(500, p, ok);
        chk("R12", "run finished despite mid-run load", ok, 1);
        chk("R12", "remain after mid-run load", remain, 0);
        cmp_mem("R3 R4 R12");
    endtask

    task automatic t_half_fixed();
        logic [9:0] c; int p, ok;
        c = mk(0, 2'b10, 2'b01, 2'b10, 2'b11, 0);
        lat = 1; init_mem();
        cfg(c, 8'h22, 8'hC6, 8); ref_xfer(c, 8'h22, 8'hC6, 8);
        go();
        chk("R9", "port mismatch ignored in continuous mode: err", err, 0);
        chk("R9", "port mismatch ignored in continuous mode: active", active, 1);
        wait_idle(500, p, ok);
        chk("R4", "fixed/decrement run finished", ok, 1);
        cmp_mem("R3 R4");
    endtask

    task automatic t_single();
        logic [9:0] c; int p, ok;
        c = mk(1, 2'b00, 2'b00, 2'b00, 2'b00, 0);
        lat = 0; init_mem();
        cfg(c, 8'h10, 8'h60, 8); ref_xfer(c, 8'h10, 8'h60, 8);
        go();
        repeat (20) @(negedge clk);
        chk("R5", "no unit moved before request", remain, 8);
        chk("R5", "bus_req low while waiting", bus_req, 0);
        pulse_req();
        repeat (20) @(negedge clk);
        chk("R5", "one unit per request", remain, 4);
        chk("R5", "still active after one unit", active, 1);
        chk("R5", "bus_req low after unit", bus_req, 0);
        pulse_req();
        wait_idle(100, p, ok);
        chk("R5", "finished after second request", ok, 1);
        chk("R8", "single mode done pulse count", p, 1);
        cmp_mem("R5");
    endtask

    task automatic t_errors();
        int p, ok;
        cfg(mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 0), 0, 8'h80, 6);
        go();
        chk("R10", "err for count not multiple of unit", err, 1);
        chk("R10", "idle after bad count", active, 0);
        cfg(mk(1, 2'b00, 2'b00, 2'b11, 2'b10, 0), 0, 8'h80, 4);
        go();
        chk("R9", "err for port mismatch in single mode", err, 1);
        chk("R9", "idle after port mismatch", active, 0);
        cfg(mk(0, 2'b00, 2'b00, 2'b11, 2'b11, 0), 0, 8'h80, 0);
        go();
        chk("R10", "err for zero count", err, 1);
        lat = 0; init_mem();
        cfg(mk(0, 2'b00, 2'b00, 2'b10, 2'b10, 0), 8'h04, 8'h84, 4);
        ref_xfer(mk(0, 2'b00, 2'b00, 2'b10, 2'b10, 0), 8'h04, 8'h84, 4);
        go();
        chk("R10", "valid start clears err", err, 0);
        chk("R10", "valid start runs", active, 1);
        wait_idle(100, p, ok);
        cmp_mem("R10");
    endtask

    task automatic t_yield_on();
        logic [9:0] c; int p, ok, viol; logic [CW-1:0] r0;
        c = mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 1);
        lat = 3; init_mem();
        cfg(c, 8'h00, 8'h80, 32); ref_xfer(c, 8'h00, 8'h80, 32);
        go();
        wait_valid();
        cpu_hold = 1'b1;
        repeat (16) @(negedge clk);
        r0 = remain; viol = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_req || bus_valid) viol++;
        end
        chk("R6", "bus activity while yielded", viol, 0);
        chk("R6", "remain frozen after one unit", remain, 28);
        chk("R6", "remain at start of window", r0, 28);
        @(negedge clk) cpu_hold = 1'b0;
        wait_idle(800, p, ok);
        chk("R6", "resumed and finished", ok, 1);
        cmp_mem("R6");
    endtask

    task automatic t_yield_off();
        logic [9:0] c; int p, ok;
        c = mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 0);
        lat = 3; init_mem();
        cfg(c, 8'h00, 8'h80, 32); ref_xfer(c, 8'h00, 8'h80, 32);
        go();
        wait_valid();
        cpu_hold = 1'b1;
        repeat (16) @(negedge clk);
        chk("R6", "bus kept with hand-back disabled", bus_req, 1);
        wait_idle(800, p, ok);
        chk("R6", "finished under hold with hand-back disabled", ok, 1);
        @(negedge clk) cpu_hold = 1'b0;
        cmp_mem("R6");
    endtask

    task automatic t_collide();
        logic [9:0] c; int p, ok;
        c = mk(0, 2'b00, 2'b00, 2'b00, 2'b00, 1);
        lat = 3; init_mem();
        cfg(c, 8'h20, 8'hA0, 4); ref_xfer(c, 8'h20, 8'hA0, 4);
        go();
        wait_valid();
        cpu_hold = 1'b1;
        wait_idle(60, p, ok);
        chk("R8", "last unit finishes despite hold", ok, 1);
        chk("R8", "done pulse with hold on last write", p, 1);
        chk("R8", "remain zero under hold", remain, 0);
        chk("R6", "bus released at end", bus_req, 0);
        @(negedge clk) cpu_hold = 1'b0;
        cmp_mem("R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_grant_word();
        t_byte_dec_ignore();
        t_half_fixed();
        t_single();
        t_errors();
        t_yield_on();
        t_yield_off();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end (R2)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule